// File: doc/BRIEF.md
# Nibble Rotate and Flag-Clear Unit

An execution slice of a 4-bit microcontroller core. The unit accepts a 12-bit instruction word with a start strobe and carries out one of two operations. The first rotates a 4-bit operand right through the carry flag. The second clears chosen bits of the four-bit flag word using an immediate mask. The unit holds working registers A and B and the flag word. A memory nibble is reached through a simple read/write port, with the address supplied by the X or Y index inputs.

Each legal instruction keeps the unit busy for a fixed number of cycles. That count is a parameter for each instruction, 5 for the rotate and 7 for the clear. At the end, a one-cycle done pulse appears together with the updated state. Opcodes outside the two ranges are not executed. Instead they give a one-cycle illegal strobe. The rest of the core loads A, B and the flags through a plain write port, which takes effect only while the unit is idle.

Top module: `nib_rot_flag_unit`

## Requirements
- R1: After reset, A, B and the flags read 0, and busy_o, done_o, illegal_o and both memory strobes are low.
- R2: Opcodes 0xE8C to 0xE8F rotate right through carry. The low two bits select the operand: 00 = A, 01 = B, 10 = memory at x_addr_i, 11 = memory at y_addr_i. The result is {C, d[3:1]} and the new C is the old d[0]. For example, 1010 with C=1 gives 1101 with C=0.
- R3: A rotate leaves flag bits 3..1 (I, D, Z) unchanged. It also leaves every register it did not select unchanged.
- R4: A memory rotate drives mem_rd_o high with the operand address in the first busy cycle. It drives mem_wr_o high with the result and the same address in the last busy cycle.
- R5: After a rotate is accepted at a clock edge, done_o is high in the cycle that follows the 5th later edge (ROT_CYC).
- R6: Opcodes 0xF50 to 0xF5F replace the flags with flags AND the low four opcode bits. The flags are ordered I, D, Z, C from bit 3 down to bit 0. For example, flags 1010 with mask 0010 give 0010.
- R7: For a flag clear, done_o is high in the cycle that follows the 7th edge after acceptance (CLR_CYC).
- R8: Any other opcode raises illegal_o for the one cycle after the edge that sampled it. It leaves busy_o low and changes no register, flag or memory.
- R9: A start or a register write that arrives while busy_o is high has no effect.
- R10: done_o is high for exactly one cycle. The register and flag results become visible in that same cycle, and they do not change at any other point during the instruction.
- R11: When idle, reg_we_i writes reg_wdata_i at the next edge. reg_wsel_i selects the target: 00 = A, 01 = B, 10 = flags, 11 = none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled while idle |
| instr_i | input | 12 | Instruction word |
| x_addr_i | input | AW | Memory index X |
| y_addr_i | input | AW | Memory index Y |
| reg_we_i | input | 1 | Register/flag write enable from the core |
| reg_wsel_i | input | 2 | Write target (00 A, 01 B, 10 flags, 11 none) |
| reg_wdata_i | input | 4 | Write data |
| mem_addr_o | output | AW | Memory nibble address |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_rdata_i | input | 4 | Memory read data, valid in the read cycle |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 4 | Memory write data |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | One-cycle illegal opcode strobe |
| reg_a_o | output | 4 | Register A |
| reg_b_o | output | 4 | Register B |
| flags_o | output | 4 | Flags {I,D,Z,C} |

## Verification
Inputs change on falling edges. Cycles are counted from the falling edge that follows the accepting rising edge. The read strobe is due at falling edge 1, the write strobe at falling edge N, and done_o at falling edge N+1, where N is 5 or 7. The illegal strobe is due at falling edge 1 and must be gone by falling edge 2. Each instruction is checked at exactly those edges. A start and a register write are injected at falling edge 1 to show that busy inputs are ignored. Results are then compared with a bench model at the done edge.

// File: rtl/nrf_pkg.sv
package nrf_pkg;
  typedef enum logic [1:0] {K_NONE, K_ROT, K_CLR, K_ILL} kind_e;
  typedef enum logic [1:0] {SEL_A = 2'd0, SEL_B = 2'd1, SEL_MX = 2'd2, SEL_MY = 2'd3} sel_e;
  localparam logic [9:0] ROT_PFX = 10'b1110_1000_11;
  localparam logic [7:0] CLR_PFX = 8'b1111_0101;
  localparam int FLAG_C = 0;
  localparam logic [1:0] WSEL_A = 2'd0;
  localparam logic [1:0] WSEL_B = 2'd1;
  localparam logic [1:0] WSEL_F = 2'd2;
endpackage

// File: rtl/nrf_decode.sv
module nrf_decode
  import nrf_pkg::*;
#(
  parameter int ROT_CYC = 5,
  parameter int CLR_CYC = 7,
  parameter int CW      = 3
) (
  input  logic [11:0]   instr_i,
  output kind_e         kind_o,
  output sel_e          sel_o,
  output logic [3:0]    mask_o,
  output logic [CW-1:0] cyc_o
);
  always_comb begin
    kind_o = K_ILL;
    cyc_o  = '0;
    sel_o  = sel_e'(instr_i[1:0]);
    mask_o = instr_i[3:0];
    if (instr_i[11:2] == ROT_PFX) begin
      kind_o = K_ROT;
      cyc_o  = CW'(ROT_CYC);
    end else if (instr_i[11:4] == CLR_PFX) begin
      kind_o = K_CLR;
      cyc_o  = CW'(CLR_CYC);
    end
  end
endmodule

// File: rtl/nrf_seq.sv
module nrf_seq #(
  parameter int CW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic [CW-1:0] cyc_i,
  output logic          busy_o,
  output logic          first_o,
  output logic          last_o,
  output logic          done_o
);
  logic [CW-1:0] cnt_q, cyc_q;
  logic          busy_q, done_q;

  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign first_o = busy_q && (cnt_q == CW'(1));
  assign last_o  = busy_q && (cnt_q == cyc_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      cyc_q  <= '0;
    end else begin
      done_q <= last_o;
      if (accept_i && !busy_q) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(1);
        cyc_q  <= cyc_i;
      end else if (busy_q) begin
        if (last_o) busy_q <= 1'b0;
        else        cnt_q  <= cnt_q + CW'(1);
      end
    end
  end

  // R10
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  // R5
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q <= cyc_q));
  // R10
  done_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(busy_q));
endmodule

// File: rtl/nrf_state.sv
module nrf_state
  import nrf_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  kind_e         kind_i,
  input  sel_e          sel_i,
  input  logic [3:0]    mask_i,
  input  logic          busy_i,
  input  logic          first_i,
  input  logic          last_i,
  input  logic [AW-1:0] x_addr_i,
  input  logic [AW-1:0] y_addr_i,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_wsel_i,
  input  logic [3:0]    reg_wdata_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_rd_o,
  input  logic [3:0]    mem_rdata_i,
  output logic          mem_wr_o,
  output logic [3:0]    mem_wdata_o,
  output logic [3:0]    reg_a_o,
  output logic [3:0]    reg_b_o,
  output logic [3:0]    flags_o
);
  kind_e      kind_q;
  sel_e       sel_q;
  logic [3:0] mask_q, opnd_q, a_q, b_q, f_q;
  logic [3:0] src, res;
  logic       mem_op;

  assign mem_op = busy_i && (kind_q == K_ROT) && (sel_q == SEL_MX || sel_q == SEL_MY);

  always_comb begin
    case (sel_q)
      SEL_A:   src = a_q;
      SEL_B:   src = b_q;
      default: src = opnd_q;
    endcase
    res = {f_q[FLAG_C], src[3:1]};
  end

  assign mem_addr_o  = (sel_q == SEL_MY) ? y_addr_i : x_addr_i;
  assign mem_rd_o    = mem_op && first_i;
  assign mem_wr_o    = mem_op && last_i;
  assign mem_wdata_o = res;
  assign reg_a_o     = a_q;
  assign reg_b_o     = b_q;
  assign flags_o     = f_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q <= K_NONE;
      sel_q  <= SEL_A;
      mask_q <= '0;
      opnd_q <= '0;
      a_q    <= '0;
      b_q    <= '0;
      f_q    <= '0;
    end else begin
      if (accept_i && !busy_i) begin
        kind_q <= kind_i;
        sel_q  <= sel_i;
        mask_q <= mask_i;
      end
      if (mem_op && first_i) opnd_q <= mem_rdata_i;
      if (busy_i && last_i) begin
        if (kind_q == K_ROT) begin
          f_q[FLAG_C] <= src[0];
          if (sel_q == SEL_A) a_q <= res;
          if (sel_q == SEL_B) b_q <= res;
        end else if (kind_q == K_CLR) begin
          f_q <= f_q & mask_q;
        end
      end else if (!busy_i && reg_we_i) begin
        case (reg_wsel_i)
          WSEL_A:  a_q <= reg_wdata_i;
          WSEL_B:  b_q <= reg_wdata_i;
          WSEL_F:  f_q <= reg_wdata_i;
          default: ;
        endcase
      end
    end
  end

  // R3
  rot_keeps_idz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && last_i && kind_q == K_ROT) |=> (f_q[3:1] == $past(f_q[3:1])));
  // R9
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !last_i) |=> ($stable(a_q) && $stable(b_q) && $stable(f_q)));
  // R4
  mem_strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_rd_o, mem_wr_o}));
  // R4
  mem_wr_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_o || mem_rd_o) |-> busy_i);
endmodule

// File: rtl/nib_rot_flag_unit.sv
module nib_rot_flag_unit
  import nrf_pkg::*;
#(
  parameter int AW      = 4,
  parameter int ROT_CYC = 5,
  parameter int CLR_CYC = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [11:0]   instr_i,
  input  logic [AW-1:0] x_addr_i,
  input  logic [AW-1:0] y_addr_i,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_wsel_i,
  input  logic [3:0]    reg_wdata_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_rd_o,
  input  logic [3:0]    mem_rdata_i,
  output logic          mem_wr_o,
  output logic [3:0]    mem_wdata_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          illegal_o,
  output logic [3:0]    reg_a_o,
  output logic [3:0]    reg_b_o,
  output logic [3:0]    flags_o
);
  localparam int MAXC = (ROT_CYC > CLR_CYC) ? ROT_CYC : CLR_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  kind_e         kind;
  sel_e          sel;
  logic [3:0]    mask;
  logic [CW-1:0] cyc;
  logic          accept, first, last, ill_q;

  nrf_decode #(.ROT_CYC(ROT_CYC), .CLR_CYC(CLR_CYC), .CW(CW)) u_dec (
    .instr_i(instr_i), .kind_o(kind), .sel_o(sel), .mask_o(mask), .cyc_o(cyc)
  );

  assign accept = start_i && !busy_o && (kind == K_ROT || kind == K_CLR);

  nrf_seq #(.CW(CW)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .accept_i(accept), .cyc_i(cyc),
    .busy_o(busy_o), .first_o(first), .last_o(last), .done_o(done_o)
  );

  nrf_state #(.AW(AW)) u_st (
    .clk_i(clk_i), .rst_ni(rst_ni), .accept_i(accept), .kind_i(kind),
    .sel_i(sel), .mask_i(mask), .busy_i(busy_o), .first_i(first), .last_i(last),
    .x_addr_i(x_addr_i), .y_addr_i(y_addr_i), .reg_we_i(reg_we_i),
    .reg_wsel_i(reg_wsel_i), .reg_wdata_i(reg_wdata_i), .mem_addr_o(mem_addr_o),
    .mem_rd_o(mem_rd_o), .mem_rdata_i(mem_rdata_i), .mem_wr_o(mem_wr_o),
    .mem_wdata_o(mem_wdata_o), .reg_a_o(reg_a_o), .reg_b_o(reg_b_o), .flags_o(flags_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ill_q <= 1'b0;
    else         ill_q <= start_i && !busy_o && (kind == K_ILL);
  end
  assign illegal_o = ill_q;

  // R8
  illegal_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !busy_o);
  // R8
  illegal_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> !illegal_o);
  // R10
  state_only_on_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |-> ($stable(reg_a_o) && $stable(reg_b_o) && $stable(flags_o)));
endmodule

// File: tb/nib_rot_flag_unit_tb.sv
module nib_rot_flag_unit_tb;
  localparam int AW = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, reg_we = 0;
  logic [11:0] instr = '0;
  logic [AW-1:0] xa = '0, ya = '0;
  logic [1:0] wsel = '0;
  logic [3:0] wdata = '0;
  logic [AW-1:0] maddr;
  logic mrd, mwr, busy, done, ill;
  logic [3:0] mrdata, mwdata, ra, rb, fl;
  logic [3:0] mem [1<<AW];
  logic [3:0] em [1<<AW];
  logic [3:0] ea = 0, eb = 0, ef = 0;
  int tests = 0, fails = 0;
  longint cycles = 0;

  always #4 clk = ~clk;

  nib_rot_flag_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .instr_i(instr),
    .x_addr_i(xa), .y_addr_i(ya), .reg_we_i(reg_we), .reg_wsel_i(wsel),
    .reg_wdata_i(wdata), .mem_addr_o(maddr), .mem_rd_o(mrd), .mem_rdata_i(mrdata),
    .mem_wr_o(mwr), .mem_wdata_o(mwdata), .busy_o(busy), .done_o(done),
    .illegal_o(ill), .reg_a_o(ra), .reg_b_o(rb), .flags_o(fl)
  );

  assign mrdata = mem[maddr];
  always @(posedge clk) if (mwr) mem[maddr] <= mwdata;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] rot(input logic [3:0] d, input logic c);
    return {d[0], c, d[3:1]}; // {new C, result}
  endfunction

  task automatic load(input logic [1:0] s, input logic [3:0] v);
    @(negedge clk);
    reg_we = 1; wsel = s; wdata = v;
    @(negedge clk);
    reg_we = 0;
    case (s)
      2'd0: ea = v;
      2'd1: eb = v;
      2'd2: ef = v;
      default: ;
    endcase
  endtask

  task automatic check_state(input string req);
    chk(ra == ea, req, ra, ea);
    chk(rb == eb, req, rb, eb);
    chk(fl == ef, req, fl, ef);
  endtask

  task automatic run(input logic [11:0] ins);
    bit is_rot, is_clr, is_mem;
    int n, k;
    logic [AW-1:0] ad;
    logic [4:0] r;
    is_rot = (ins[11:2] == 10'b1110_1000_11);
    is_clr = (ins[11:4] == 8'hF5);
    is_mem = is_rot && ins[1];
    n  = is_rot ? 5 : 7;
    ad = ins[0] ? ya : xa;
    @(negedge clk);
    start = 1; instr = ins;
    @(negedge clk);
    k = 1;
    if (!is_rot && !is_clr) begin
      start = 0;
      chk(ill == 1'b1, "R8 illegal strobe", ill, 1);
      chk(busy == 1'b0, "R8 not busy", busy, 0);
      @(negedge clk);
      chk(ill == 1'b0, "R8 single strobe", ill, 0);
      check_state("R8 state kept");
      for (int i = 0; i < (1<<AW); i++) chk(mem[i] == em[i], "R8 memory kept", mem[i], em[i]);
      return;
    end
    // inject start and register write while busy
    start = 1; instr = 12'hF50; reg_we = 1; wsel = 2'd2; wdata = 4'hF;
    chk(busy == 1'b1, "R9 busy", busy, 1);
    if (is_mem) begin
      chk(mrd == 1'b1, "R4 read strobe", mrd, 1);
      chk(maddr == ad, "R4 read addr", maddr, ad);
    end
    while (!done && k < 20) begin
      @(negedge clk);
      k++;
      start = 0; reg_we = 0;
      if (k == n && is_mem) begin
        chk(mwr == 1'b1, "R4 write strobe", mwr, 1);
        chk(maddr == ad, "R4 write addr", maddr, ad);
      end
      if (k <= n) chk(!done, is_rot ? "R5 early done" : "R7 early done", done, 0);
    end
    chk(k == n + 1, is_rot ? "R5 rotate latency" : "R7 clear latency", k, n + 1);
    if (is_rot) begin
      case (ins[1:0])
        2'd0: begin r = rot(ea, ef[0]); ea = r[3:0]; end
        2'd1: begin r = rot(eb, ef[0]); eb = r[3:0]; end
        default: begin r = rot(em[ad], ef[0]); em[ad] = r[3:0]; end
      endcase
      ef[0] = r[4];
      check_state("R2/R3 rotate result");
      if (is_mem) chk(mem[ad] == em[ad], "R4 memory result", mem[ad], em[ad]);
    end else begin
      ef = ef & ins[3:0];
      check_state("R6 flag clear result");
    end
    @(negedge clk);
    chk(done == 1'b0, "R10 done one cycle", done, 0);
    check_state("R9 busy inputs ignored");
  endtask

  initial begin
    void'($urandom(32'h5EED));
    for (int i = 0; i < (1<<AW); i++) begin
      mem[i] = 4'($urandom);
      em[i] = mem[i];
    end
    #21 rst_n = 1;
    @(negedge clk);
    // R1
    chk(ra == 0 && rb == 0 && fl == 0, "R1 reset regs", {ra, rb, fl}, 0);
    chk(!busy && !done && !ill && !mrd && !mwr, "R1 reset strobes",
        {busy, done, ill, mrd, mwr}, 0);
    // R11 loads
    load(2'd0, 4'b1010);
    load(2'd2, 4'b1011);
    load(2'd3, 4'h7);
    check_state("R11 register write");
    // R2 directed
    run(12'hE8C);
    chk(ra == 4'b1101 && fl[0] == 1'b0, "R2 1010 C1 -> 1101 C0", {ra, fl}, {4'b1101, 4'b1010});
    // R6 directed
    load(2'd2, 4'b1010);
    run(12'hF52);
    chk(fl == 4'b0010, "R6 1010&0010", fl, 4'b0010);
    // memory via X and Y
    xa = 4'd3; ya = 4'd9;
    run(12'hE8E);
    run(12'hE8F);
    run(12'hE8D);
    // illegal edges
    run(12'hE8B);
    run(12'hF60);
    run(12'hF4F);
    run(12'h000);
    run(12'hF5F);
    run(12'hF50);
    for (int t = 0; t < 200; t++) begin
      int c;
      logic [11:0] w;
      xa = AW'($urandom); ya = AW'($urandom);
      c = $urandom % 4;
      case (c)
        0: run(12'hE8C | 12'($urandom % 4));
        1: run(12'hF50 | 12'($urandom % 16));
        2: begin
          w = 12'($urandom);
          run(w);
        end
        default: load(2'($urandom), 4'($urandom));
      endcase
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule